// File: doc/BRIEF.md
# Dual-Link Tower Frame Deserializer

This block merges the word streams of two serial-link receivers into one calorimeter tower frame per bunch crossing. Each link delivers a burst of eight 16-bit words per crossing, opened by a start-of-frame marker. Words from link A fill frame words 0 to 7 and words from link B fill frame words 8 to 15, in arrival order. The result is a 256-bit frame.

On each crossing boundary, marked by a one-cycle crossing-rate enable, the block checks whether both links completed their bursts. If they did, it latches the frame and pulses frame-valid. It then cuts the frame into 15 tower records of 17 bits each and presents each record as separate ECAL, HCAL and finegrain fields for the downstream cluster logic. A link that falls short sets a sticky error and suppresses the pulse for that crossing.

The whole block runs on one clock. Word strobes arrive on that clock, and crossing boundaries come from the enable.

Top module: `tower_frame_deser`

## Requirements
- R1: During and after reset, before any boundary, frame_valid is 0, frame_error is 0, and every tower field is 0.
- R2: A word with lnk_a_valid and lnk_a_sof both high is stored as frame word 0. Each later lnk_a_valid word is stored as the next frame word, up to word 7. Link B fills frame words 8 to 15 the same way. Frame word j occupies frame bits [16j+15:16j].
- R3: Tower k takes frame bits [17k+16:17k]. Its ECAL field is frame bits [17k+7:17k], on tower_ecal[8k+7:8k]. Its HCAL field is frame bits [17k+15:17k+8], on tower_hcal[8k+7:8k]. Its finegrain bit is frame bit 17k+16, on tower_fg[k]. Frame bit 255 is ignored.
- R4: A boundary is a cycle with xing_en high. If both links received a start-of-frame and eight words since the previous boundary, frame_valid is high for exactly the cycle after the boundary, and the fields show the new frame in that cycle. Words on the boundary cycle count toward the next crossing.
- R5: If either link has fewer than eight words at a boundary, frame_valid stays low and frame_error becomes 1 in the cycle after the boundary. The tower fields keep their previous values.
- R6: Words a link delivers after its eighth word in the same crossing are ignored.
- R7: A new start-of-frame on a link discards that link's earlier words in the crossing and restarts filling at word 0.
- R8: Valid words that arrive on a link before its first start-of-frame in a crossing are ignored.
- R9: The tower fields change only in a cycle where frame_valid is high.
- R10: Once set, frame_error stays 1 until reset, including across later complete crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for words and boundaries |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_en | input | 1 | Crossing-boundary enable, one cycle per crossing |
| lnk_a_valid | input | 1 | Link A word strobe |
| lnk_a_sof | input | 1 | Link A start-of-frame, qualified by lnk_a_valid |
| lnk_a_word | input | 16 | Link A data word |
| lnk_b_valid | input | 1 | Link B word strobe |
| lnk_b_sof | input | 1 | Link B start-of-frame, qualified by lnk_b_valid |
| lnk_b_word | input | 16 | Link B data word |
| frame_valid | output | 1 | One-cycle pulse when a new frame is presented |
| frame_error | output | 1 | Sticky short-link indicator |
| tower_ecal | output | 120 | ECAL Et of 15 towers, 8 bits each |
| tower_hcal | output | 120 | HCAL Et of 15 towers, 8 bits each |
| tower_fg | output | 15 | Finegrain bit of each tower |

## Verification
A wrong word counter or fill pointer in a link collector shows up at the first boundary that follows. Either the frame carries shifted or stale tower fields when frame_valid pulses, or the pulse is missing and frame_error rises, one cycle after xing_en. A collector that accepts words it should drop (stray words before start-of-frame, extra words, discarded partial bursts) corrupts particular towers in the same crossing. A wrong error or hold state is seen as a pulse or field change in a crossing where none belongs.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
   // width of one tower record: two energy fields plus finegrain bit
   function automatic int tower_rec_w(input int et_w);
      return 2 * et_w + 1;
   endfunction
endpackage

// File: rtl/tfd_link_collector.sv
module tfd_link_collector #(
   parameter int WORD_W = 16,
   parameter int WORDS  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bound_i,
   input  logic                     valid_i,
   input  logic                     sof_i,
   input  logic [WORD_W-1:0]        word_i,
   output logic                     done_o,
   output logic [WORDS*WORD_W-1:0]  words_o
);
   localparam int CNT_W = $clog2(WORDS + 1);
   localparam int IDX_W = $clog2(WORDS);

   generate
      if (WORDS < 2) begin : g_bad_depth
         $error("tfd_link_collector: WORDS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt;
   logic              started;
   logic [WORD_W-1:0] slot [WORDS];
   logic              restart;
   logic              take;

   assign restart = valid_i && sof_i;
   assign take    = valid_i && !sof_i && started && !bound_i
                    && (cnt < CNT_W'(WORDS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         started <= 1'b0;
      end else if (restart) begin
         cnt     <= CNT_W'(1);
         started <= 1'b1;
      end else if (bound_i) begin
         cnt     <= '0;
         started <= 1'b0;
      end else if (take) begin
         cnt     <= cnt + CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (restart) begin
         slot[0] <= word_i;
      end else if (take) begin
         slot[cnt[IDX_W-1:0]] <= word_i;
      end
   end

   assign done_o = started && (cnt == CNT_W'(WORDS));

   generate
      for (genvar g = 0; g < WORDS; g++) begin : g_out
         assign words_o[g*WORD_W +: WORD_W] = slot[g];
      end
   endgenerate

   // R4: completion is only ever reached by accepting a word
   assert_done_needs_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(valid_i));
   // R6: the fill count never passes the burst length
   assert_no_overfill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && valid_i && !sof_i |=> $stable(words_o));
endmodule

// File: rtl/tfd_record_slicer.sv
module tfd_record_slicer #(
   parameter int NUM_TOWERS = 15,
   parameter int ET_W       = 8
) (
   input  logic [NUM_TOWERS*tfd_pkg::tower_rec_w(ET_W)-1:0] frame_i,
   output logic [NUM_TOWERS*ET_W-1:0]                        ecal_o,
   output logic [NUM_TOWERS*ET_W-1:0]                        hcal_o,
   output logic [NUM_TOWERS-1:0]                             fg_o
);
   localparam int REC_W = tfd_pkg::tower_rec_w(ET_W);

   generate
      for (genvar k = 0; k < NUM_TOWERS; k++) begin : g_tower
         assign ecal_o[k*ET_W +: ET_W] = frame_i[k*REC_W +: ET_W];
         assign hcal_o[k*ET_W +: ET_W] = frame_i[k*REC_W + ET_W +: ET_W];
         assign fg_o[k]                = frame_i[k*REC_W + 2*ET_W];
      end
   endgenerate
endmodule

// File: rtl/tower_frame_deser.sv
module tower_frame_deser #(
   parameter int WORD_W     = 16,
   parameter int WORDS      = 8,
   parameter int NUM_TOWERS = 15,
   parameter int ET_W       = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       xing_en,
   input  logic                       lnk_a_valid,
   input  logic                       lnk_a_sof,
   input  logic [WORD_W-1:0]          lnk_a_word,
   input  logic                       lnk_b_valid,
   input  logic                       lnk_b_sof,
   input  logic [WORD_W-1:0]          lnk_b_word,
   output logic                       frame_valid,
   output logic                       frame_error,
   output logic [NUM_TOWERS*ET_W-1:0] tower_ecal,
   output logic [NUM_TOWERS*ET_W-1:0] tower_hcal,
   output logic [NUM_TOWERS-1:0]      tower_fg
);
   localparam int LINK_W  = WORDS * WORD_W;
   localparam int FRAME_W = 2 * LINK_W;
   localparam int REC_W   = tfd_pkg::tower_rec_w(ET_W);
   localparam int USED_W  = NUM_TOWERS * REC_W;

   generate
      if (USED_W > FRAME_W) begin : g_bad_fit
         $error("tower_frame_deser: towers do not fit in the frame");
      end
   endgenerate

   logic              a_done, b_done;
   logic [LINK_W-1:0] a_words, b_words;
   logic [USED_W-1:0] frame_q;

   tfd_link_collector #(.WORD_W(WORD_W), .WORDS(WORDS)) u_link_a (
      .clk(clk), .rst_n(rst_n), .bound_i(xing_en),
      .valid_i(lnk_a_valid), .sof_i(lnk_a_sof), .word_i(lnk_a_word),
      .done_o(a_done), .words_o(a_words));

   tfd_link_collector #(.WORD_W(WORD_W), .WORDS(WORDS)) u_link_b (
      .clk(clk), .rst_n(rst_n), .bound_i(xing_en),
      .valid_i(lnk_b_valid), .sof_i(lnk_b_sof), .word_i(lnk_b_word),
      .done_o(b_done), .words_o(b_words));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q     <= '0;
         frame_valid <= 1'b0;
         frame_error <= 1'b0;
      end else begin
         frame_valid <= 1'b0;
         if (xing_en) begin
            if (a_done && b_done) begin
               frame_q     <= USED_W'({b_words, a_words});
               frame_valid <= 1'b1;
            end else begin
               frame_error <= 1'b1;
            end
         end
      end
   end

   tfd_record_slicer #(.NUM_TOWERS(NUM_TOWERS), .ET_W(ET_W)) u_slicer (
      .frame_i(frame_q), .ecal_o(tower_ecal), .hcal_o(tower_hcal), .fg_o(tower_fg));

   // R4: a frame is only presented right after a crossing boundary
   assert_fv_after_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(xing_en));
   // R5: the crossing that raises the error presents no frame
   assert_short_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_error) |-> !frame_valid);
   // R9: tower fields hold between frame pulses
   assert_hold_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> ($stable(tower_ecal) && $stable(tower_hcal) && $stable(tower_fg)));
   // R10: the error flag never clears on its own
   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_error |=> frame_error);
endmodule

// File: tb/tower_frame_deser_tb.sv
`timescale 1ns/1ps
module tower_frame_deser_tb;
   localparam int NT = 15;
   localparam int EW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xing_en = 1'b0;
   logic a_valid = 1'b0, a_sof = 1'b0, b_valid = 1'b0, b_sof = 1'b0;
   logic [15:0] a_word = '0, b_word = '0;
   logic frame_valid, frame_error;
   logic [NT*EW-1:0] tower_ecal, tower_hcal;
   logic [NT-1:0] tower_fg;

   int checks = 0;
   int failures = 0;
   logic [255:0] exp_q [$];
   logic [255:0] last_frame = '0;
   logic exp_err = 1'b0;
   logic mon_on = 1'b0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   tower_frame_deser u_dut (
      .clk(clk), .rst_n(rst_n), .xing_en(xing_en),
      .lnk_a_valid(a_valid), .lnk_a_sof(a_sof), .lnk_a_word(a_word),
      .lnk_b_valid(b_valid), .lnk_b_sof(b_sof), .lnk_b_word(b_word),
      .frame_valid(frame_valid), .frame_error(frame_error),
      .tower_ecal(tower_ecal), .tower_hcal(tower_hcal), .tower_fg(tower_fg));

   function automatic logic [15:0] gen_word(int pat, int link, int i);
      if (pat == 1) return 16'hFFFF;
      if (pat == 2) return (link == 0) ? 16'hA5A5 : 16'h5A5A;
      return 16'((pat + 1) * 16'h3B9D) ^ 16'((link * 8 + i + 1) * 16'h0F1D);
   endfunction

   // compare outputs with fields cut from a frame per R3
   task automatic cmp_fields(input logic [255:0] fr, input string tag);
      logic [NT*EW-1:0] ee, eh;
      logic [NT-1:0] ef;
      for (int k = 0; k < NT; k++) begin
         ee[k*EW +: EW] = fr[17*k +: 8];
         eh[k*EW +: EW] = fr[17*k + 8 +: 8];
         ef[k]          = fr[17*k + 16];
      end
      checks++;
      if (tower_ecal !== ee || tower_hcal !== eh || tower_fg !== ef) begin
         failures++;
         $display("FAIL %s fields: ecal=%h hcal=%h fg=%h expected ecal=%h hcal=%h fg=%h",
                  tag, tower_ecal, tower_hcal, tower_fg, ee, eh, ef);
      end
   endtask

   // monitor: pops the scoreboard on every frame pulse, checks hold otherwise
   always @(negedge clk) begin
      if (mon_on && !done) begin
         if (frame_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
               failures++;
               $display("FAIL R4 unexpected frame_valid: actual=1 expected=0");
            end else begin
               last_frame = exp_q.pop_front();
               cmp_fields(last_frame, "R2/R3");
            end
         end else begin
            cmp_fields(last_frame, "R9 hold");
         end
      end
   end

   // pre: 0 none, 1 stray words without sof (R8), 2 burst later restarted (R7)
   task automatic crossing(int pat, int na, int nb, int pre, int extra);
      logic [255:0] fr;
      logic good;
      fr = '0;
      for (int i = 0; i < 8; i++) begin
         fr[16*i +: 16]     = gen_word(pat, 0, i);
         fr[16*(i+8) +: 16] = gen_word(pat, 1, i);
      end
      good = (na == 8) && (nb == 8);
      if (good) exp_q.push_back(fr);
      else exp_err = 1'b1;
      for (int c = 0; c < 14; c++) begin
         @(negedge clk);
         xing_en = (c == 13);
         a_valid = 1'b0; a_sof = 1'b0; a_word = 16'h0000;
         b_valid = 1'b0; b_sof = 1'b0; b_word = 16'h0000;
         if (pre != 0 && (c == 1 || c == 2)) begin
            a_valid = 1'b1; b_valid = 1'b1;
            a_word = 16'hDEAD; b_word = 16'hDEAD;
            a_sof = (pre == 2 && c == 1); b_sof = (pre == 2 && c == 1);
         end
         if (c >= 3 && c < 3 + na) begin
            a_valid = 1'b1; a_sof = (c == 3); a_word = gen_word(pat, 0, c - 3);
         end
         if (c >= 3 && c < 3 + nb) begin
            b_valid = 1'b1; b_sof = (c == 3); b_word = gen_word(pat, 1, c - 3);
         end
         if (extra != 0 && (c == 11 || c == 12)) begin
            if (na == 8) begin a_valid = 1'b1; a_word = 16'hBEEF; end
            if (nb == 8) begin b_valid = 1'b1; b_word = 16'hBEEF; end
         end
      end
      @(negedge clk);
      xing_en = 1'b0;
      a_valid = 1'b0; a_sof = 1'b0; b_valid = 1'b0; b_sof = 1'b0;
      checks++;
      if (frame_valid !== good) begin
         failures++;
         $display("FAIL %s frame_valid: actual=%b expected=%b", good ? "R4" : "R5",
                  frame_valid, good);
      end
      checks++;
      if (frame_error !== exp_err) begin
         failures++;
         $display("FAIL R5/R10 frame_error: actual=%b expected=%b", frame_error, exp_err);
      end
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      checks++;
      if (frame_valid !== 1'b0 || frame_error !== 1'b0) begin
         failures++;
         $display("FAIL R1 flags in reset: actual=%b%b expected=00", frame_valid, frame_error);
      end
      cmp_fields('0, "R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      cmp_fields('0, "R1 after reset");
      mon_on = 1'b1;
      crossing(0, 8, 8, 0, 0);   // R2 R3 R4 ordinary frame
      crossing(1, 8, 8, 0, 0);   // all ones, R3 bit 255 ignored
      crossing(2, 8, 8, 0, 0);   // alternating pattern
      crossing(3, 8, 8, 0, 1);   // R6 extra words
      crossing(4, 8, 8, 1, 0);   // R8 stray words before sof
      crossing(5, 8, 8, 2, 0);   // R7 restarted burst
      crossing(6, 5, 8, 0, 0);   // R5 short link A
      crossing(7, 8, 8, 0, 0);   // R10 error stays on a good frame
      crossing(8, 8, 0, 0, 0);   // R5 link B silent
      crossing(9, 8, 8, 1, 1);   // R6 R8 together
      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL R4 frames not presented: actual=%0d left expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule